// File: doc/BRIEF.md
# Receive Byte Queue with Fill Trigger and Idle Timeout

This block holds bytes delivered by a line receiver until the CPU side collects them. Each accepted byte enters a 16-entry circular queue tracked by a write pointer, a read pointer and an occupancy count. The count is always visible on an output port. The oldest byte is shown at the read port, and a one-cycle pop strobe retires it.

The block raises a receive-ready flag, and optionally an interrupt, in two cases. The first is when the occupancy reaches a threshold picked from four fixed values. The second is when a few bytes sit below that threshold for 15 elementary time units with no further arrivals. Each elementary time unit is marked by a one-cycle tick from a baud-rate source; at the default rate this corresponds to 9600 baud.

Software-side strobes can empty the queue or clear the flag. The serial deserializer and error detection are outside this block.

Top module: `rx_trig_fifo`

## Requirements
- R1: After reset, fill_count is 0 and rx_full and rx_irq are both 0.
- R2: trig_sel sets the threshold: 2'b00 gives 1, 2'b01 gives 4, 2'b10 gives 8 and 2'b11 gives 14. An accepted byte that brings the count to or above the threshold sets rx_full at that clock edge.
- R3: A byte on rx_valid is accepted only while rx_en is 1 and the count is below 16. Any other byte is dropped, so the count never exceeds 16 and the stored bytes are unchanged.
- R4: pop_data shows the oldest stored byte, and bytes leave in arrival order. A pop while the queue is empty has no effect, and the count stays 0.
- R5: If an accepted byte and a pop fall in the same cycle, the count is unchanged and both pointers advance.
- R6: A pop that leaves the count below the threshold clears rx_full, unless a set event happens in the same cycle.
- R7: Any event that sets rx_full also sets rx_irq, but only while rx_ie is 1. flag_clr clears both rx_full and rx_irq. rx_irq is forced to 0 whenever rx_ie is 0. A set event wins over flag_clr in the same cycle.
- R8: An accepted byte that leaves the count below the threshold restarts an idle timer at 15 etu_tick pulses. rx_full (and rx_irq if enabled) is set at the edge of the 15th tick. A byte that reaches the threshold while rx_ie is 1 cancels the timer.
- R9: After the timer fires, it stays idle until the next accepted byte. Later ticks do not set rx_full again.
- R10: fifo_clr empties the queue, zeroes both pointers and the count, clears rx_full and stops the timer. It overrides any push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_en | input | 1 | Receive enable |
| rx_ie | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Threshold select |
| fifo_clr | input | 1 | Empty the queue |
| flag_clr | input | 1 | Clear rx_full and rx_irq |
| etu_tick | input | 1 | One elementary time unit elapsed |
| pop | input | 1 | Retire the byte on pop_data |
| pop_data | output | 8 | Oldest stored byte, 0 when empty |
| fill_count | output | 5 | Number of stored bytes |
| rx_full | output | 1 | Receive-ready flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
The two functions that can fall in the same cycle are a byte arriving from the line and a CPU pop. A single cycle can therefore add to and take from the count, and the flag decision depends on where the count lands. The stimulus table drives rx_valid and pop together at two points. The first is at the threshold, where the arrival must re-set rx_full and the count must stay put. The second is just below it, where the arrival restarts the idle timer while the pop clears rx_full. In both cases the bench judges the count, the flag, the interrupt and the byte order that later pops reveal.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   typedef enum logic [1:0] {
      TRIG_A = 2'b00,
      TRIG_B = 2'b01,
      TRIG_C = 2'b10,
      TRIG_D = 2'b11
   } trig_sel_e;

   // Map the two-bit selection onto one of four configured thresholds.
   function automatic int unsigned pick_trigger(input logic [1:0] sel,
                                                input int unsigned ta,
                                                input int unsigned tb,
                                                input int unsigned tc,
                                                input int unsigned td);
      case (trig_sel_e'(sel))
         TRIG_A:  return ta;
         TRIG_B:  return tb;
         TRIG_C:  return tc;
         default: return td;
      endcase
   endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned PW   = $clog2(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wipe,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] count
);

   logic [DW-1:0] mem_q [DEPTH];
   logic [PW-1:0] wr_ptr_q, rd_ptr_q, wr_ptr_nx, rd_ptr_nx;
   logic [CW-1:0] count_q;

   // Pointer wrap: free-running for power-of-two depths, compare otherwise.
   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
      assign wr_ptr_nx = wr_ptr_q + 1'b1;
      assign rd_ptr_nx = rd_ptr_q + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_ptr_nx = (wr_ptr_q == PW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
      assign rd_ptr_nx = (rd_ptr_q == PW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push) begin
         mem_q[wr_ptr_q] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else if (wipe) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push) wr_ptr_q <= wr_ptr_nx;
         if (pop)  rd_ptr_q <= rd_ptr_nx;
         case ({push, pop})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign rdata = (count_q != '0) ? mem_q[rd_ptr_q] : '0;
   assign count = count_q;

endmodule

// File: rtl/rxf_idle_timer.sv
module rxf_idle_timer #(
   parameter int unsigned LIMIT = 15,
   localparam int unsigned TW   = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wipe,
   input  logic restart,
   input  logic cancel,
   input  logic tick,
   output logic expire
);

   logic          active_q;
   logic [TW-1:0] remain_q;

   assign expire = active_q && tick && (remain_q == TW'(1)) && !restart && !wipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         remain_q <= '0;
      end else if (wipe || cancel) begin
         active_q <= 1'b0;
         remain_q <= '0;
      end else if (restart) begin
         active_q <= 1'b1;
         remain_q <= TW'(LIMIT);
      end else if (active_q && tick) begin
         if (remain_q == TW'(1)) begin
            active_q <= 1'b0;
            remain_q <= '0;
         end else begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic wipe,
   input  logic set_evt,
   input  logic drop_evt,
   input  logic flag_clr,
   input  logic ie,
   output logic full,
   output logic irq
);

   logic full_q, irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
      end else if (wipe) begin
         full_q <= 1'b0;
      end else if (set_evt) begin
         full_q <= 1'b1;
      end else if (drop_evt || flag_clr) begin
         full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else if (!ie) begin
         irq_q <= 1'b0;
      end else if (set_evt) begin
         irq_q <= 1'b1;
      end else if (flag_clr) begin
         irq_q <= 1'b0;
      end
   end

   assign full = full_q;
   assign irq  = irq_q;

endmodule

// File: rtl/rx_trig_fifo.sv
module rx_trig_fifo
   import rxf_pkg::*;
#(
   parameter int unsigned DW          = 8,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned TRIG_A_VAL  = 1,
   parameter int unsigned TRIG_B_VAL  = 4,
   parameter int unsigned TRIG_C_VAL  = 8,
   parameter int unsigned TRIG_D_VAL  = 14,
   parameter int unsigned TIMEOUT_ETU = 15,
   localparam int unsigned CW         = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rx_valid,
   input  logic [DW-1:0] rx_data,
   input  logic          rx_en,
   input  logic          rx_ie,
   input  logic [1:0]    trig_sel,
   input  logic          fifo_clr,
   input  logic          flag_clr,
   input  logic          etu_tick,
   input  logic          pop,
   output logic [DW-1:0] pop_data,
   output logic [CW-1:0] fill_count,
   output logic          rx_full,
   output logic          rx_irq
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rx_trig_fifo: DEPTH must be at least 2");
   end
   if (TRIG_A_VAL < 1 || TRIG_B_VAL < 1 || TRIG_C_VAL < 1 || TRIG_D_VAL < 1) begin : g_bad_trig_lo
      $error("rx_trig_fifo: thresholds must be at least 1");
   end
   if (TRIG_A_VAL > DEPTH || TRIG_B_VAL > DEPTH || TRIG_C_VAL > DEPTH || TRIG_D_VAL > DEPTH) begin : g_bad_trig_hi
      $error("rx_trig_fifo: thresholds must not exceed DEPTH");
   end
   if (TIMEOUT_ETU < 1) begin : g_bad_timeout
      $error("rx_trig_fifo: TIMEOUT_ETU must be at least 1");
   end

   logic [CW-1:0] count;
   logic [CW:0]   count_after;
   logic [CW:0]   threshold;
   logic          push_ok, pop_ok, reach, below, expire;

   assign threshold = (CW+1)'(pick_trigger(trig_sel, TRIG_A_VAL, TRIG_B_VAL,
                                           TRIG_C_VAL, TRIG_D_VAL));

   assign push_ok = rx_valid && rx_en && (count < CW'(DEPTH)) && !fifo_clr;
   assign pop_ok  = pop && (count != '0) && !fifo_clr;

   assign count_after = {1'b0, count} + (CW+1)'(push_ok) - (CW+1)'(pop_ok);
   assign reach       = push_ok && (count_after >= threshold);
   assign below       = count_after < threshold;

   rxf_store #(
      .DW    (DW),
      .DEPTH (DEPTH)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wipe  (fifo_clr),
      .push  (push_ok),
      .pop   (pop_ok),
      .wdata (rx_data),
      .rdata (pop_data),
      .count (count)
   );

   rxf_idle_timer #(
      .LIMIT (TIMEOUT_ETU)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .wipe    (fifo_clr),
      .restart (push_ok && below),
      .cancel  (reach && rx_ie),
      .tick    (etu_tick),
      .expire  (expire)
   );

   rxf_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .wipe     (fifo_clr),
      .set_evt  (reach || expire),
      .drop_evt (pop_ok && below),
      .flag_clr (flag_clr),
      .ie       (rx_ie),
      .full     (rx_full),
      .irq      (rx_irq)
   );

   assign fill_count = count;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker
   import rxf_pkg::*;
#(
   parameter int unsigned DEPTH      = 16,
   parameter int unsigned TRIG_A_VAL = 1,
   parameter int unsigned TRIG_B_VAL = 4,
   parameter int unsigned TRIG_C_VAL = 8,
   parameter int unsigned TRIG_D_VAL = 14,
   localparam int unsigned CW        = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rx_valid,
   input logic          rx_en,
   input logic          rx_ie,
   input logic [1:0]    trig_sel,
   input logic          fifo_clr,
   input logic          flag_clr,
   input logic          etu_tick,
   input logic          pop,
   input logic [CW-1:0] fill_count,
   input logic          rx_full,
   input logic          rx_irq
);

   int unsigned thr;
   assign thr = pick_trigger(trig_sel, TRIG_A_VAL, TRIG_B_VAL, TRIG_C_VAL, TRIG_D_VAL);

   assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fill_count <= CW'(DEPTH));

   assert_disabled_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!rx_en && !pop && !fifo_clr) |=> $stable(fill_count));

   assert_pop_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && fill_count == '0 && !rx_valid && !fifo_clr) |=> fill_count == '0);

   assert_push_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_en && pop && fill_count != '0 && fill_count < CW'(DEPTH) && !fifo_clr)
      |=> $stable(fill_count));

   assert_reach_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_en && !pop && !fifo_clr && fill_count < CW'(DEPTH)
       && (int'(fill_count) + 1 >= int'(thr))) |=> rx_full);

   assert_pop_below_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !rx_valid && !etu_tick && fill_count != '0
       && (int'(fill_count) - 1 < int'(thr))) |=> !rx_full);

   assert_irq_needs_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_ie |=> !rx_irq);

   assert_flag_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !rx_valid && !etu_tick) |=> (!rx_full && !rx_irq));

   assert_clr_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr |=> (fill_count == '0 && !rx_full));

endmodule

bind rx_trig_fifo rxf_checker #(
   .DEPTH      (DEPTH),
   .TRIG_A_VAL (TRIG_A_VAL),
   .TRIG_B_VAL (TRIG_B_VAL),
   .TRIG_C_VAL (TRIG_C_VAL),
   .TRIG_D_VAL (TRIG_D_VAL)
) u_rxf_checker (
   .clk        (clk),
   .rst_n      (rst_n),
   .rx_valid   (rx_valid),
   .rx_en      (rx_en),
   .rx_ie      (rx_ie),
   .trig_sel   (trig_sel),
   .fifo_clr   (fifo_clr),
   .flag_clr   (flag_clr),
   .etu_tick   (etu_tick),
   .pop        (pop),
   .fill_count (fill_count),
   .rx_full    (rx_full),
   .rx_irq     (rx_irq)
);

// File: tb/sim_rx_trig_fifo.sv
module sim_rx_trig_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;

   // Table run with trig_sel = 2'b01 (threshold 4), rx_en = 1, rx_ie = 1.
   // Step k pushes byte 8'h40 + k when V_PUSH[k] is 1.
   localparam int V_PUSH [NVEC] = '{1, 1, 1, 1, 1, 0, 1, 0, 1, 1};
   localparam int V_POP  [NVEC] = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0};
   localparam int V_CNT  [NVEC] = '{1, 2, 3, 4, 4, 3, 3, 2, 3, 4};
   localparam int V_FULL [NVEC] = '{0, 0, 0, 1, 1, 0, 0, 0, 0, 1};
   localparam int V_IRQ  [NVEC] = '{0, 0, 0, 1, 1, 1, 1, 1, 1, 1};
   localparam int V_RD   [NVEC] = '{0, 0, 0, 0, 'h40, 'h41, 'h42, 'h43, 0, 0};
   localparam int THR    [4]    = '{1, 4, 8, 14};

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_valid = 1'b0;
   logic [7:0] rx_data = '0;
   logic       rx_en = 1'b1;
   logic       rx_ie = 1'b1;
   logic [1:0] trig_sel = 2'b01;
   logic       fifo_clr = 1'b0;
   logic       flag_clr = 1'b0;
   logic       etu_tick = 1'b0;
   logic       pop = 1'b0;
   logic [7:0] pop_data;
   logic [4:0] fill_count;
   logic       rx_full;
   logic       rx_irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rx_trig_fifo u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data),
      .rx_en      (rx_en),
      .rx_ie      (rx_ie),
      .trig_sel   (trig_sel),
      .fifo_clr   (fifo_clr),
      .flag_clr   (flag_clr),
      .etu_tick   (etu_tick),
      .pop        (pop),
      .pop_data   (pop_data),
      .fill_count (fill_count),
      .rx_full    (rx_full),
      .rx_irq     (rx_irq)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic idle();
      rx_valid = 1'b0; pop = 1'b0; fifo_clr = 1'b0; flag_clr = 1'b0; etu_tick = 1'b0;
   endtask

   task automatic push_byte(input logic [7:0] b);
      rx_valid = 1'b1; rx_data = b; step(); idle();
   endtask

   task automatic wipe();
      fifo_clr = 1'b1; step(); idle();
   endtask

   task automatic clear_flag();
      flag_clr = 1'b1; step(); idle();
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         etu_tick = 1'b1; step();
      end
      etu_tick = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      chk("R1", "fill_count", int'(fill_count), 0);
      chk("R1", "rx_full", int'(rx_full), 0);
      chk("R1", "rx_irq", int'(rx_irq), 0);

      // Vector table: R2, R4, R5, R6, R7
      for (int k = 0; k < NVEC; k++) begin
         rx_valid = V_PUSH[k] != 0;
         rx_data  = 8'(8'h40 + k);
         pop      = V_POP[k] != 0;
         if (V_POP[k] != 0) chk("R4", "pop_data", int'(pop_data), V_RD[k]);
         step();
         idle();
         chk("R5", "fill_count", int'(fill_count), V_CNT[k]);
         chk("R6", "rx_full", int'(rx_full), V_FULL[k]);
         chk("R7", "rx_irq", int'(rx_irq), V_IRQ[k]);
      end

      // R2 each threshold encoding, interrupt disabled
      rx_ie = 1'b0;
      for (int s = 0; s < 4; s++) begin
         wipe();
         trig_sel = 2'(s);
         for (int i = 0; i < THR[s] - 1; i++) push_byte(8'(i));
         chk("R2", "rx_full below threshold", int'(rx_full), 0);
         push_byte(8'hAA);
         chk("R2", "rx_full at threshold", int'(rx_full), 1);
      end

      // R3 disabled receive drops bytes
      wipe();
      rx_en = 1'b0;
      push_byte(8'h77);
      chk("R3", "count with rx_en low", int'(fill_count), 0);
      rx_en = 1'b1;

      // R3 overflow discards, R4 order
      trig_sel = 2'b11;
      for (int i = 0; i < 17; i++) push_byte(8'(8'h10 + i));
      chk("R3", "count saturates", int'(fill_count), 16);
      for (int i = 0; i < 16; i++) begin
         chk("R4", "pop order", int'(pop_data), 8'h10 + i);
         pop = 1'b1; step(); idle();
      end
      chk("R4", "count after drain", int'(fill_count), 0);
      pop = 1'b1; step(); idle();
      chk("R4", "pop on empty", int'(fill_count), 0);

      // R8 timeout with interrupt enabled
      rx_ie = 1'b1;
      trig_sel = 2'b01;
      wipe();
      clear_flag();
      push_byte(8'h01);
      ticks(14);
      chk("R8", "rx_full after 14 ticks", int'(rx_full), 0);
      ticks(1);
      chk("R8", "rx_full after 15 ticks", int'(rx_full), 1);
      chk("R8", "rx_irq after 15 ticks", int'(rx_irq), 1);
      clear_flag();
      chk("R7", "rx_full after flag_clr", int'(rx_full), 0);
      chk("R7", "rx_irq after flag_clr", int'(rx_irq), 0);
      ticks(20);
      chk("R9", "no second timeout", int'(rx_full), 0);

      // R8 cancel by reaching threshold
      push_byte(8'h02); push_byte(8'h03); push_byte(8'h04);
      chk("R8", "rx_full at threshold", int'(rx_full), 1);
      clear_flag();
      ticks(20);
      chk("R8", "timer cancelled", int'(rx_full), 0);

      // R7 irq dropped when rx_ie goes low
      push_byte(8'h05);
      chk("R7", "rx_irq set by push", int'(rx_irq), 1);
      rx_ie = 1'b0; step();
      chk("R7", "rx_irq with rx_ie low", int'(rx_irq), 0);

      // R7 timeout without interrupt
      wipe();
      push_byte(8'h06);
      ticks(15);
      chk("R7", "rx_full timeout ie off", int'(rx_full), 1);
      chk("R7", "rx_irq timeout ie off", int'(rx_irq), 0);

      // R10 clear overrides push, stops timer
      rx_valid = 1'b1; fifo_clr = 1'b1; step(); idle();
      chk("R10", "count after clear", int'(fill_count), 0);
      chk("R10", "rx_full after clear", int'(rx_full), 0);
      push_byte(8'h07);
      wipe();
      ticks(20);
      chk("R10", "timer idle after clear", int'(rx_full), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule